// File: doc/BRIEF.md
# UART FIFO Control and DMA Request Logic

This block is the FIFO control section of a 16550-style UART. It accepts writes to an 8-bit FIFO control word and keeps the occupancy counts of a transmit FIFO and a receive FIFO. Each FIFO holds `DEPTH` characters, 16 by default. When FIFO mode is off, each side becomes a single-entry holding register. From the receive occupancy and a selectable trigger threshold, the block produces the received-data-available interrupt and the auto flow control `rts_n` output. From both occupancies it produces active-low DMA request lines, either one transfer at a time or in bursts.

The character storage, the serial shifter and the baud logic sit outside this block. They report every character written, sent, received or read through one-cycle push and pop strobes. Any reset of the FIFO control state opens a fixed settling window of `SETTLE` cycles. While that window is open, `busy` is high, the block ignores the strobes and withdraws both DMA requests.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: After reset both levels read 0, `busy` is 0, FIFO mode is off, `rx_avail_irq` and `rts_n` are 0, `dma_tx_req_n` is 0 and `dma_rx_req_n` is 1.
- R2: With FIFO mode on, control bits [7:6] set the receive threshold: 00 gives 1 character, 01 gives DEPTH/4, 10 gives DEPTH/2 and 11 gives DEPTH-2. `rx_avail_irq` is 1 exactly when the receive level is at or above the threshold.
- R3: Control bit 0 turns FIFO mode on. With it off, each level saturates at 1 and the receive threshold is 1 character whatever bits [7:6] hold.
- R4: `rts_n` is 1 when `afc_en` is 1 and the receive level is at or above the threshold. Otherwise it is 0.
- R5: A write with bit 2 set clears the transmit level on that clock edge and leaves the receive level alone. The bit does not persist: a later write without it clears nothing.
- R6: A write with bit 1 set clears the receive level on that clock edge and leaves the transmit level alone.
- R7: A write whose bit 0 differs from the current FIFO-mode setting clears both levels. A write that keeps bit 0 and has bits 2:1 clear changes no level and does not start the settling window.
- R8: Every clearing write raises `busy` for exactly SETTLE (8) cycles after its clock edge. While `busy` is high, push and pop strobes have no effect and both DMA request outputs are 1.
- R9: A push to a full side and a pop from an empty side are ignored. A level never exceeds its capacity: DEPTH in FIFO mode, 1 otherwise.
- R10: With control bit 3 at 0 (single mode), `dma_tx_req_n` is 0 exactly when the transmit level is 0, and `dma_rx_req_n` is 0 exactly when the receive level is at least 1.
- R11: With control bit 3 at 1 (burst mode), `dma_tx_req_n` goes to 0 when the transmit level is 0 and stays 0 until the level reaches capacity. It then stays 1 until the level returns to 0.
- R12: In burst mode, `dma_rx_req_n` goes to 0 when the receive level reaches the threshold and stays 0 until the level returns to 0.
- R13: Bits [5:4] and [31:8] of a control write are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| afc_en | input | 1 | Auto flow control enable |
| tx_push | input | 1 | One character written to the transmit side |
| tx_pop | input | 1 | One character taken by the transmitter |
| rx_push | input | 1 | One character received |
| rx_pop | input | 1 | One character read from the receive side |
| tx_level | output | 5 | Transmit occupancy |
| rx_level | output | 5 | Receive occupancy |
| busy | output | 1 | Settling window after a FIFO reset |
| rx_avail_irq | output | 1 | Receive level at or above the threshold |
| rts_n | output | 1 | Flow control output, 1 = stop sending |
| dma_tx_req_n | output | 1 | Transmit DMA request, active low |
| dma_rx_req_n | output | 1 | Receive DMA request, active low |

## Verification
The properties assume that every strobe lasts one clock and reflects one character. They assume that a clearing write, not a strobe, is the only thing that moves a level while `busy` is high. They also assume that a control write lasts one cycle. The bench drives each strobe and write for exactly one cycle on the falling edge. It never pushes and pops the same side in the same cycle, and it issues no control write while checking the settling window's stability. Over-full pushes, empty pops and strobes during the window are applied on purpose, one at a time, so that each reaches the design on its own clock edge.

// File: rtl/uart_fifo_pkg.sv
// Package: shared control-word types and the receive threshold decode.
// Assumes DEPTH is a multiple of 4 and at least 4.
package uart_fifo_pkg;

    typedef enum logic [1:0] {
        TRIG_ONE       = 2'b00,
        TRIG_QUARTER   = 2'b01,
        TRIG_HALF      = 2'b10,
        TRIG_NEAR_FULL = 2'b11
    } rx_trig_e;

    typedef struct packed {
        rx_trig_e trig;
        logic     burst;
        logic     fifo_on;
    } fcr_cfg_t;

    // Receive threshold in characters for a given code and mode.
    function automatic int unsigned trig_count(rx_trig_e t, logic on, int unsigned depth);
        if (!on) return 1;
        case (t)
            TRIG_QUARTER:   return depth / 4;
            TRIG_HALF:      return depth / 2;
            TRIG_NEAR_FULL: return depth - 2;
            default:        return 1;
        endcase
    endfunction

endpackage

// File: rtl/uart_fcr_regs.sv
// Control word register. It holds the enable, DMA mode and trigger fields.
// A write produces one-cycle clear pulses for the self-clearing FIFO resets and for an enable change.
// It also runs the settling counter. Assumes cfg_we lasts one cycle per write.
module uart_fcr_regs
    import uart_fifo_pkg::*;
#(
    parameter int unsigned SETTLE = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [7:0]  cfg_byte,
    output fcr_cfg_t    cfg,
    output logic        tx_clr,
    output logic        rx_clr,
    output logic        busy
);
    localparam int unsigned BW = $clog2(SETTLE + 1);

    logic          en_flip;
    logic [BW-1:0] settle_q;

    // Decode the clear pulses from the incoming write.
    always_comb begin
        en_flip = cfg_we && (cfg_byte[0] != cfg.fifo_on);
        tx_clr  = en_flip || (cfg_we && cfg_byte[2]);
        rx_clr  = en_flip || (cfg_we && cfg_byte[1]);
    end

    // Register the persistent fields. Bits 2:1 and 5:4 are not stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '{trig: TRIG_ONE, burst: 1'b0, fifo_on: 1'b0};
        end else if (cfg_we) begin
            cfg <= '{trig: rx_trig_e'(cfg_byte[7:6]), burst: cfg_byte[3], fifo_on: cfg_byte[0]};
        end
    end

    // Settling counter: reload on any clear, count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            settle_q <= '0;
        end else if (tx_clr || rx_clr) begin
            settle_q <= BW'(SETTLE);
        end else if (settle_q != '0) begin
            settle_q <= settle_q - 1'b1;
        end
    end

    assign busy = (settle_q != '0);

endmodule

// File: rtl/uart_fifo_level.sv
// Occupancy counter for one FIFO side. Capacity is DEPTH in FIFO mode and 1 otherwise.
// Pushes at capacity, pops at zero and any strobe while held are dropped. A clear wins over strobes.
module uart_fifo_level #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          hold,
    input  logic          fifo_on,
    input  logic          push,
    input  logic          pop,
    output logic [CW-1:0] level
);
    logic [CW-1:0] cap;
    logic          inc, dec;

    // Qualify the strobes against capacity and the settling hold.
    always_comb begin
        cap = fifo_on ? CW'(DEPTH) : CW'(1);
        inc = push && !hold && (level < cap);
        dec = pop  && !hold && (level != '0);
    end

    // Update the occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            level <= '0;
        end else if (inc && !dec) begin
            level <= level + 1'b1;
        end else if (dec && !inc) begin
            level <= level - 1'b1;
        end
    end

endmodule

// File: rtl/uart_dma_req.sv
// DMA request generation for both directions.
// Single mode follows the empty and non-empty state. Burst mode latches a request until the far limit.
// Both requests are withdrawn while the settling window is open.
module uart_dma_req
    import uart_fifo_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  fcr_cfg_t      cfg,
    input  logic          busy,
    input  logic [CW-1:0] tx_level,
    input  logic [CW-1:0] rx_level,
    input  logic          rx_hit,
    output logic          dma_tx_req_n,
    output logic          dma_rx_req_n
);
    logic [CW-1:0] cap;
    logic          tx_burst_q, rx_burst_q;
    logic          tx_want, rx_want;

    // Request conditions for the selected mode.
    always_comb begin
        cap     = cfg.fifo_on ? CW'(DEPTH) : CW'(1);
        tx_want = (tx_level == '0) || (cfg.burst && tx_burst_q && (tx_level != cap));
        rx_want = cfg.burst ? (rx_hit || (rx_burst_q && (rx_level != '0)))
                            : (rx_level != '0);
        dma_tx_req_n = !(tx_want && !busy);
        dma_rx_req_n = !(rx_want && !busy);
    end

    // Remember an open burst from cycle to cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_burst_q <= 1'b0;
            rx_burst_q <= 1'b0;
        end else begin
            tx_burst_q <= tx_want;
            rx_burst_q <= rx_want;
        end
    end

endmodule

// File: rtl/uart_fifo_ctrl.sv
// Top of the UART FIFO control section. It ties the control register, two occupancy counters and the DMA request logic together.
// It derives the threshold-based interrupt and flow control output.
// Assumes push and pop strobes are one cycle per character.
module uart_fifo_ctrl
    import uart_fifo_pkg::*;
#(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned SETTLE = 8,
    localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [31:0]   cfg_wdata,
    input  logic          afc_en,
    input  logic          tx_push,
    input  logic          tx_pop,
    input  logic          rx_push,
    input  logic          rx_pop,
    output logic [CW-1:0] tx_level,
    output logic [CW-1:0] rx_level,
    output logic          busy,
    output logic          rx_avail_irq,
    output logic          rts_n,
    output logic          dma_tx_req_n,
    output logic          dma_rx_req_n
);
    fcr_cfg_t      cfg;
    logic          tx_clr, rx_clr;
    logic          fifo_on_w, burst_w;
    logic [CW-1:0] thr;
    logic          rx_hit;
    logic          unused_rsvd;

    assign unused_rsvd = ^{cfg_wdata[31:8], cfg_wdata[5:4]};
    assign fifo_on_w   = cfg.fifo_on;
    assign burst_w     = cfg.burst;

    uart_fcr_regs #(.SETTLE(SETTLE)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_byte (cfg_wdata[7:0]),
        .cfg      (cfg),
        .tx_clr   (tx_clr),
        .rx_clr   (rx_clr),
        .busy     (busy)
    );

    uart_fifo_level #(.DEPTH(DEPTH)) tx_lvl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tx_clr),
        .hold    (busy),
        .fifo_on (cfg.fifo_on),
        .push    (tx_push),
        .pop     (tx_pop),
        .level   (tx_level)
    );

    uart_fifo_level #(.DEPTH(DEPTH)) rx_lvl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (rx_clr),
        .hold    (busy),
        .fifo_on (cfg.fifo_on),
        .push    (rx_push),
        .pop     (rx_pop),
        .level   (rx_level)
    );

    // Threshold compare that feeds the interrupt, flow control and receive DMA.
    always_comb begin
        thr          = CW'(trig_count(cfg.trig, cfg.fifo_on, DEPTH));
        rx_hit       = (rx_level >= thr);
        rx_avail_irq = rx_hit;
        rts_n        = afc_en && rx_hit;
    end

    uart_dma_req #(.DEPTH(DEPTH)) dma_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg          (cfg),
        .busy         (busy),
        .tx_level     (tx_level),
        .rx_level     (rx_level),
        .rx_hit       (rx_hit),
        .dma_tx_req_n (dma_tx_req_n),
        .dma_rx_req_n (dma_rx_req_n)
    );

endmodule

// File: rtl/uart_fifo_ctrl_chk.sv
// Checker for uart_fifo_ctrl, attached by bind. It observes ports and the stored mode bits.
// It assumes one-cycle strobes and writes.
module uart_fifo_ctrl_chk #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_we,
    input logic [2:0]    wlow,
    input logic          fifo_on,
    input logic          burst,
    input logic          busy,
    input logic [CW-1:0] tx_level,
    input logic [CW-1:0] rx_level,
    input logic          dma_tx_req_n,
    input logic          dma_rx_req_n
);
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level <= CW'(DEPTH)) && (rx_level <= CW'(DEPTH)));

    a_r3_single_entry: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_on |-> (tx_level <= CW'(1)) && (rx_level <= CW'(1)));

    a_r5_tx_flush: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && wlow[2] |=> (tx_level == '0) && busy);

    a_r6_rx_flush: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && wlow[1] |=> (rx_level == '0) && busy);

    a_r7_enable_flush: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && (wlow[0] != fifo_on) |=> (tx_level == '0) && (rx_level == '0) && busy);

    a_r8_levels_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !cfg_we |=> $stable(tx_level) && $stable(rx_level));

    a_r8_requests_idle: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> dma_tx_req_n && dma_rx_req_n);

    a_r11_burst_hold: assert property (@(posedge clk) disable iff (!rst_n)
        burst && fifo_on && !busy && !dma_tx_req_n && !cfg_we
        |=> !dma_tx_req_n || (tx_level == CW'(DEPTH)));

    a_r12_rx_burst_hold: assert property (@(posedge clk) disable iff (!rst_n)
        burst && !busy && !dma_rx_req_n && !cfg_we && (rx_level > CW'(1))
        |=> !dma_rx_req_n);

endmodule

bind uart_fifo_ctrl uart_fifo_ctrl_chk #(.DEPTH(DEPTH), .CW(CW)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .wlow         (cfg_wdata[2:0]),
    .fifo_on      (fifo_on_w),
    .burst        (burst_w),
    .busy         (busy),
    .tx_level     (tx_level),
    .rx_level     (rx_level),
    .dma_tx_req_n (dma_tx_req_n),
    .dma_rx_req_n (dma_rx_req_n)
);

// File: tb/uart_fifo_ctrl_tb_top.sv
// Directed bench for uart_fifo_ctrl. Inputs change on the falling edge and outputs are sampled there.
module uart_fifo_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        afc_en = 1'b0;
    logic        tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
    logic [4:0]  tx_level, rx_level;
    logic        busy, rx_avail_irq, rts_n, dma_tx_req_n, dma_rx_req_n;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    uart_fifo_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .afc_en(afc_en), .tx_push(tx_push), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_pop(rx_pop), .tx_level(tx_level),
        .rx_level(rx_level), .busy(busy), .rx_avail_irq(rx_avail_irq),
        .rts_n(rts_n), .dma_tx_req_n(dma_tx_req_n), .dma_rx_req_n(dma_rx_req_n)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        cfg_we = 1'b1; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0; cfg_wdata = '0;
    endtask

    // sel: 0 tx_push, 1 tx_pop, 2 rx_push, 3 rx_pop
    task automatic strobe(input int sel, input int n);
        for (int i = 0; i < n; i++) begin
            tx_push = (sel == 0); tx_pop = (sel == 1);
            rx_push = (sel == 2); rx_pop = (sel == 3);
            @(negedge clk);
            tx_push = 1'b0; tx_pop = 1'b0; rx_push = 1'b0; rx_pop = 1'b0;
        end
    endtask

    task automatic settle();
        for (int i = 0; i < 20 && busy; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 tx_level", tx_level, 0);
        chk("R1 rx_level", rx_level, 0);
        chk("R1 busy", busy, 0);
        chk("R1 irq", rx_avail_irq, 0);
        chk("R1 rts_n", rts_n, 0);
        chk("R1 tx_req_n", dma_tx_req_n, 0);
        chk("R1 rx_req_n", dma_rx_req_n, 1);
    endtask

    task automatic t_fifo_off();
        afc_en = 1'b1;
        strobe(0, 2);
        chk("R3 tx saturates at 1", tx_level, 1);
        strobe(2, 1);
        chk("R3 irq at one char", rx_avail_irq, 1);
        chk("R4 rts_n at threshold", rts_n, 1);
        strobe(2, 1);
        chk("R3 rx saturates at 1", rx_level, 1);
        strobe(3, 1);
        chk("R3 irq clears", rx_avail_irq, 0);
        chk("R4 rts_n below threshold", rts_n, 0);
    endtask

    task automatic t_enable();
        int n;
        wr(32'h01);
        chk("R7 enable flush tx", tx_level, 0);
        chk("R8 busy after enable", busy, 1);
        chk("R8 tx req idle", dma_tx_req_n, 1);
        n = 0;
        for (int i = 0; i < 20 && busy; i++) begin n++; @(negedge clk); end
        chk("R8 window length", n, 8);
        chk("R8 tx req after window", dma_tx_req_n, 0);
    endtask

    task automatic t_trig();
        int thr [4] = '{1, 4, 8, 14};
        for (int c = 0; c < 4; c++) begin
            wr(32'(c << 6) | 32'h01);
            chk("R7 no busy on same enable", busy, 0);
            strobe(2, thr[c] - 1);
            chk("R2 irq below threshold", rx_avail_irq, 0);
            chk("R4 rts_n below threshold", rts_n, 0);
            strobe(2, 1);
            chk("R2 irq at threshold", rx_avail_irq, 1);
            chk("R4 rts_n at threshold", rts_n, 1);
            wr(32'(c << 6) | 32'h03);
            chk("R6 rx flush", rx_level, 0);
            settle();
        end
        afc_en = 1'b0;
        strobe(2, 1);
        chk("R4 rts_n low with afc off", rts_n, 0);
        wr(32'h03); settle();
    endtask

    task automatic t_tx_flush();
        strobe(2, 2);
        strobe(0, 3);
        wr(32'h05);
        chk("R5 tx flush", tx_level, 0);
        chk("R6 rx kept on tx flush", rx_level, 2);
        strobe(0, 1);
        chk("R8 push ignored while busy", tx_level, 0);
        settle();
        strobe(0, 2);
        wr(32'h01);
        chk("R5 bit does not persist", tx_level, 2);
        chk("R5 no busy after plain write", busy, 0);
        wr(32'h07); settle();
    endtask

    task automatic t_bounds();
        strobe(0, 17);
        chk("R9 tx capped", tx_level, 16);
        strobe(3, 1);
        chk("R9 pop at empty", rx_level, 0);
        strobe(2, 18);
        chk("R9 rx capped", rx_level, 16);
        wr(32'h07); settle();
    endtask

    task automatic t_dma0();
        chk("R10 tx req at empty", dma_tx_req_n, 0);
        chk("R10 rx no req at empty", dma_rx_req_n, 1);
        strobe(0, 1);
        chk("R10 tx req drops after one char", dma_tx_req_n, 1);
        strobe(2, 1);
        chk("R10 rx req with one char", dma_rx_req_n, 0);
        wr(32'h07); settle();
    endtask

    task automatic t_dma1();
        wr(32'h89);
        chk("R11 mode change no busy", busy, 0);
        chk("R11 tx req at empty", dma_tx_req_n, 0);
        strobe(0, 15);
        chk("R11 tx req held below full", dma_tx_req_n, 0);
        strobe(0, 1);
        chk("R11 tx req drops at full", dma_tx_req_n, 1);
        strobe(1, 1);
        chk("R11 tx req stays off after pop", dma_tx_req_n, 1);
        strobe(1, 15);
        chk("R11 tx req back at empty", dma_tx_req_n, 0);
        strobe(2, 7);
        chk("R12 rx no req below threshold", dma_rx_req_n, 1);
        strobe(2, 1);
        chk("R12 rx req at threshold", dma_rx_req_n, 0);
        strobe(3, 7);
        chk("R12 rx req held to last char", dma_rx_req_n, 0);
        strobe(3, 1);
        chk("R12 rx req drops at empty", dma_rx_req_n, 1);
    endtask

    task automatic t_reserved();
        wr(32'hFFFF_FFB9);
        chk("R13 reserved bits start nothing", busy, 0);
        strobe(2, 7);
        chk("R13 threshold still half, below", rx_avail_irq, 0);
        strobe(2, 1);
        chk("R13 threshold still half, at", rx_avail_irq, 1);
        chk("R13 levels intact", tx_level, 0);
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fifo_off();
        t_enable();
        t_trig();
        t_tx_flush();
        t_bounds();
        t_dma0();
        t_dma1();
        t_reserved();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule